// File: doc/BRIEF.md
# Infrared SIR Pulse Encoder/Decoder with Low-Power Option

This block sits between a UART and an infrared transceiver. The UART hands it the serial transmit line, `uart_txd`, together with a strobe, `os_tick`, that pulses sixteen times per bit period. In the encoder, every zero bit becomes one short active-high pulse on `ir_tx`, and every one bit leaves `ir_tx` low. The pulse width depends on the mode:

- **Normal mode:** the pulse spans three strobe periods, which is 3/16 of a bit.
- **Low-power mode:** the pulse spans three periods of a slow clock. An 8-bit prescaler `psc` divides the system clock to produce that slow clock. For example, `psc` of about 27 at a 50 MHz system clock gives roughly 1.8 MHz.

The decoder takes the active-low pulses arriving from the transceiver on `ir_rx`. It synchronizes them and measures each low run in system-clock cycles. It discards runs that are too short to be real, and stretches each accepted pulse into one full bit period of low on `uart_rxd`, which idles high. The thresholds are multiples of the prescaler period, so one register sets both the transmit width and the glitch limit. A prescaler value of zero is a forbidden setting: with it, the slow clock is stopped.

Top module: `irda_sir_codec`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `ir_tx` is 0 and `uart_rxd` is 1.
- R2: In normal mode (`lp_mode`=0), each zero bit on `uart_txd` makes `ir_tx` go high on the clock edge at which the bit's first `os_tick` is sampled. `ir_tx` stays high for exactly 3 `os_tick` periods. `psc` has no effect in this mode.
- R3: A one bit on `uart_txd` produces no pulse. In normal mode, `ir_tx` is low after any `os_tick` at which `uart_txd` is 1.
- R4: A run of consecutive zero bits produces one separate pulse per bit, each starting 16 `os_tick` periods after the previous one.
- R5: In low-power mode (`lp_mode`=1) with `psc`>0, each zero bit makes `ir_tx` high for exactly 3×`psc` system-clock cycles, starting on the same edge as in R2, whatever the `os_tick` rate.
- R6: With `psc`=0, `ir_tx` stays low in low-power mode, and the decoder accepts no pulse in either mode.
- R7: In normal mode, a low on `ir_rx` lasting fewer than `psc` system-clock cycles is discarded. A low lasting `psc` cycles or more is accepted.
- R8: In low-power mode, a low on `ir_rx` is accepted only if it lasts at least 2×`psc`+1 system-clock cycles.
- R9: An accepted pulse drives `uart_rxd` low for 16 `os_tick` periods counted from the acceptance. The decoder accepts at most once per low run on `ir_rx`, however long that run lasts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lp_mode | input | 1 | 0 selects normal pulse width, 1 selects low-power width |
| psc | input | 8 | Low-power clock divider, in system-clock cycles per period; 0 stops that clock |
| os_tick | input | 1 | One-cycle strobe, 16 per bit period |
| uart_txd | input | 1 | UART-level transmit line, idle high |
| ir_tx | output | 1 | Encoded pulses to the transceiver, active high |
| ir_rx | input | 1 | Pulses from the transceiver, active low |
| uart_rxd | output | 1 | Decoded UART-level receive line, idle high |

## Verification
The bench builds the block with its default widths: an 8-bit prescaler, 16 strobes per bit and a two-flop input synchronizer. It drives `os_tick` every 4 system clocks, so one bit lasts 64 cycles. At that scale the bench can sweep every low-pulse length from 1 up to past both acceptance thresholds, for several `psc` values in both modes. It can also walk low-power transmit widths over a range of prescaler settings, all within a short run. The expected pulse counts, widths and stretch lengths follow arithmetically from `psc` and the strobe spacing.

// File: rtl/irda_sir_pkg.sv
package irda_sir_pkg;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_LOWPWR = 1'b1
    } sir_mode_e;

    function automatic sir_mode_e to_mode(input logic sel);
        return sel ? MODE_LOWPWR : MODE_NORMAL;
    endfunction

endpackage

// File: rtl/irda_lp_divider.sv
module irda_lp_divider #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PSC_W-1:0] psc,
    input  logic             restart,
    output logic             lp_tick
);
    typedef struct packed {
        logic [PSC_W-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;
    logic    tick_c;

    always_comb begin
        st_d   = st_q;
        tick_c = 1'b0;
        if (restart || (psc == '0)) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == psc - PSC_W'(1)) begin
            tick_c   = 1'b1;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + PSC_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lp_tick = tick_c;
endmodule

// File: rtl/irda_sir_tx.sv
module irda_sir_tx
    import irda_sir_pkg::*;
#(
    parameter int PSC_W         = 8,
    parameter int OS_RATIO      = 16,
    parameter int PULSE_TICKS   = 3,
    parameter int LP_TX_PERIODS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sir_mode_e        mode,
    input  logic [PSC_W-1:0] psc,
    input  logic             os_tick,
    input  logic             uart_txd,
    output logic             ir_tx
);
    localparam int PH_W  = $clog2(OS_RATIO);
    localparam int CNT_W = $clog2(LP_TX_PERIODS + 1);

    typedef struct packed {
        logic             txd;
        logic [PH_W-1:0]  phase;
        logic             pulse;
        logic [CNT_W-1:0] lpcnt;
    } tx_st_t;

    tx_st_t          st_d, st_q;
    logic [PH_W-1:0] phase_nx;
    logic            bit_start;
    logic            restart;
    logic            lp_tick;

    irda_lp_divider #(.PSC_W(PSC_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .psc     (psc),
        .restart (restart),
        .lp_tick (lp_tick)
    );

    always_comb begin
        st_d    = st_q;
        restart = 1'b0;

        // Bit boundary: a level change realigns the phase, otherwise it wraps every OS_RATIO ticks
        if (uart_txd != st_q.txd)                  phase_nx = '0;
        else if (st_q.phase == PH_W'(OS_RATIO - 1)) phase_nx = '0;
        else                                        phase_nx = st_q.phase + PH_W'(1);

        bit_start = os_tick && (phase_nx == '0);

        if (os_tick) begin
            st_d.txd   = uart_txd;
            st_d.phase = phase_nx;
        end

        if (mode == MODE_NORMAL) begin
            st_d.lpcnt = '0;
            if (os_tick) begin
                st_d.pulse = !uart_txd && (phase_nx < PH_W'(PULSE_TICKS));
            end
        end else if (psc == '0) begin
            st_d.pulse = 1'b0;
            st_d.lpcnt = '0;
        end else if (bit_start && !uart_txd) begin
            st_d.pulse = 1'b1;
            st_d.lpcnt = '0;
            restart    = 1'b1;
        end else if (st_q.pulse && lp_tick) begin
            if (st_q.lpcnt == CNT_W'(LP_TX_PERIODS - 1)) begin
                st_d.pulse = 1'b0;
                st_d.lpcnt = '0;
            end else begin
                st_d.lpcnt = st_q.lpcnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.txd   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ir_tx = st_q.pulse;
endmodule

// File: rtl/irda_sir_rx.sv
module irda_sir_rx
    import irda_sir_pkg::*;
#(
    parameter int PSC_W         = 8,
    parameter int OS_RATIO      = 16,
    parameter int RX_LP_PERIODS = 2,
    parameter int SYNC_STAGES   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sir_mode_e        mode,
    input  logic [PSC_W-1:0] psc,
    input  logic             os_tick,
    input  logic             ir_rx,
    output logic             uart_rxd
);
    localparam int PH_W = $clog2(OS_RATIO);
    localparam int CW   = PSC_W + $clog2(RX_LP_PERIODS + 1) + 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CW-1:0]          lowcnt;
        logic                   fired;
        logic                   act;
        logic [PH_W-1:0]        oscnt;
    } rx_st_t;

    rx_st_t        st_d, st_q;
    logic          line_low;
    logic          fire;
    logic [CW-1:0] thr;
    logic [CW-1:0] cnt_inc;

    always_comb begin
        st_d     = st_q;
        fire     = 1'b0;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], ir_rx};
        line_low = !st_q.sync[SYNC_STAGES-1];
        cnt_inc  = st_q.lowcnt + CW'(1);

        if (mode == MODE_LOWPWR) thr = CW'(RX_LP_PERIODS) * CW'(psc) + CW'(1);
        else                     thr = CW'(psc);

        // Glitch filter: count the low run, accept once when it reaches the threshold
        if (!line_low) begin
            st_d.lowcnt = '0;
            st_d.fired  = 1'b0;
        end else if (!st_q.fired && (psc != '0)) begin
            st_d.lowcnt = cnt_inc;
            if (cnt_inc == thr) begin
                fire       = 1'b1;
                st_d.fired = 1'b1;
            end
        end

        // Stretch each accepted pulse to one bit period
        if (fire) begin
            st_d.act   = 1'b1;
            st_d.oscnt = '0;
        end else if (st_q.act && os_tick) begin
            if (st_q.oscnt == PH_W'(OS_RATIO - 1)) begin
                st_d.act   = 1'b0;
                st_d.oscnt = '0;
            end else begin
                st_d.oscnt = st_q.oscnt + PH_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.sync <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign uart_rxd = !st_q.act;
endmodule

// File: rtl/irda_sir_codec.sv
module irda_sir_codec
    import irda_sir_pkg::*;
#(
    parameter int PSC_W         = 8,
    parameter int OS_RATIO      = 16,
    parameter int PULSE_TICKS   = 3,
    parameter int LP_TX_PERIODS = 3,
    parameter int RX_LP_PERIODS = 2,
    parameter int SYNC_STAGES   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lp_mode,
    input  logic [PSC_W-1:0] psc,
    input  logic             os_tick,
    input  logic             uart_txd,
    output logic             ir_tx,
    input  logic             ir_rx,
    output logic             uart_rxd
);
    sir_mode_e mode;
    assign mode = to_mode(lp_mode);

    irda_sir_tx #(
        .PSC_W         (PSC_W),
        .OS_RATIO      (OS_RATIO),
        .PULSE_TICKS   (PULSE_TICKS),
        .LP_TX_PERIODS (LP_TX_PERIODS)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .psc      (psc),
        .os_tick  (os_tick),
        .uart_txd (uart_txd),
        .ir_tx    (ir_tx)
    );

    irda_sir_rx #(
        .PSC_W         (PSC_W),
        .OS_RATIO      (OS_RATIO),
        .RX_LP_PERIODS (RX_LP_PERIODS),
        .SYNC_STAGES   (SYNC_STAGES)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .psc      (psc),
        .os_tick  (os_tick),
        .ir_rx    (ir_rx),
        .uart_rxd (uart_rxd)
    );
endmodule

// File: rtl/irda_sir_checker.sv
module irda_sir_checker #(
    parameter int PSC_W         = 8,
    parameter int LP_TX_PERIODS = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lp_mode,
    input logic [PSC_W-1:0] psc,
    input logic             os_tick,
    input logic             uart_txd,
    input logic             ir_tx,
    input logic             uart_rxd
);
    localparam int RW = PSC_W + 4;

    logic [RW-1:0] hi_run_q;
    logic [RW-1:0] lp_limit;

    assign lp_limit = RW'(LP_TX_PERIODS) * RW'(psc);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hi_run_q <= '0;
        else if (ir_tx) hi_run_q <= hi_run_q + RW'(1);
        else            hi_run_q <= '0;
    end

    // R1: outputs idle right after reset release
    a_r1_reset_idle: assert property (@(posedge clk)
        $rose(rst_n) |-> (!ir_tx && uart_rxd));

    // R3: a high transmit line sampled on a strobe leaves no pulse in normal mode
    a_r3_one_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (!lp_mode && os_tick && uart_txd) |=> !ir_tx);

    // R6: stopped low-power clock means no transmit pulse
    a_r6_psc0_tx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_mode && psc == '0) |=> !ir_tx);

    // R6: stopped low-power clock means no decoded low starts
    a_r6_psc0_rx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (psc == '0 && uart_rxd) |=> uart_rxd);

    // R5: a low-power pulse never outlasts three prescaler periods
    a_r5_lp_width_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_mode && $stable(lp_mode) && $stable(psc) && psc != '0 && ir_tx)
            |-> (hi_run_q < lp_limit));
endmodule

bind irda_sir_codec irda_sir_checker #(
    .PSC_W         (PSC_W),
    .LP_TX_PERIODS (LP_TX_PERIODS)
) u_sir_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lp_mode  (lp_mode),
    .psc      (psc),
    .os_tick  (os_tick),
    .uart_txd (uart_txd),
    .ir_tx    (ir_tx),
    .uart_rxd (uart_rxd)
);

// File: tb/tb_irda_sir_codec.sv
module tb_irda_sir_codec;
    localparam int OS_DIV = 4;
    localparam int OSR    = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lp_mode = 1'b0;
    logic [7:0] psc = 8'd1;
    logic       os_tick = 1'b0;
    logic       uart_txd = 1'b1;
    logic       ir_rx = 1'b1;
    logic       ir_tx;
    logic       uart_rxd;

    int n_chk = 0;
    int n_fail = 0;
    int gcnt = 0;
    int lead_hits = 0;

    int tx_pulses = 0, tx_wmin = 0, tx_wmax = 0, tx_run = 0;
    int rx_falls = 0, rx_wmin = 0, rx_wmax = 0, rx_run = 0;
    bit tx_prev = 1'b0;
    bit rx_prev = 1'b1;

    always #10 clk = ~clk;

    irda_sir_codec dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .lp_mode  (lp_mode),
        .psc      (psc),
        .os_tick  (os_tick),
        .uart_txd (uart_txd),
        .ir_tx    (ir_tx),
        .ir_rx    (ir_rx),
        .uart_rxd (uart_rxd)
    );

    always @(negedge clk) begin
        if (ir_tx) begin
            tx_run++;
        end else if (tx_prev) begin
            tx_pulses++;
            if (tx_pulses == 1 || tx_run < tx_wmin) tx_wmin = tx_run;
            if (tx_run > tx_wmax) tx_wmax = tx_run;
            tx_run = 0;
        end
        tx_prev = ir_tx;
        if (!uart_rxd) begin
            if (rx_prev) rx_falls++;
            rx_run++;
        end else if (!rx_prev) begin
            if (rx_falls == 1 || rx_run < rx_wmin) rx_wmin = rx_run;
            if (rx_run > rx_wmax) rx_wmax = rx_run;
            rx_run = 0;
        end
        rx_prev = uart_rxd;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        os_tick = (gcnt % OS_DIV == 0);
        gcnt++;
    endtask

    task automatic send_bit(input bit b);
        while (gcnt % OS_DIV != 0) cyc();
        @(negedge clk);
        uart_txd = b;
        os_tick  = 1'b1;
        gcnt++;
        cyc();
        if (!b && ir_tx) lead_hits++;
        repeat (OSR * OS_DIV - 2) cyc();
    endtask

    task automatic clear_mon();
        tx_pulses = 0; tx_wmin = 0; tx_wmax = 0;
        rx_falls = 0;  rx_wmin = 0; rx_wmax = 0;
        lead_hits = 0;
    endtask

    // Sends start + 8 data bits LSB first + stop; checks pulse count, widths, leading edge
    task automatic frame(input logic [7:0] b, input int width, input string req);
        int zeros;
        zeros = 1;
        for (int i = 0; i < 8; i++) if (!b[i]) zeros++;
        if (width == 0) zeros = 0;
        repeat (20) cyc();
        clear_mon();
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(b[i]);
        send_bit(1'b1);
        repeat (40) cyc();
        chk(tx_pulses == zeros, req, "pulse count", tx_pulses, zeros);
        if (zeros > 0) begin
            chk(tx_wmin == width && tx_wmax == width, req, "pulse width",
                (tx_wmin == width) ? tx_wmax : tx_wmin, width);
            chk(lead_hits == zeros, req, "pulse at bit start", lead_hits, zeros);
        end
    endtask

    task automatic rx_trial(input int len, input int exp_falls, input string req);
        repeat (10) cyc();
        clear_mon();
        cyc();
        ir_rx = 1'b0;
        repeat (len) cyc();
        ir_rx = 1'b1;
        repeat (100) cyc();
        chk(rx_falls == exp_falls, req, $sformatf("accept count len=%0d", len),
            rx_falls, exp_falls);
        if (exp_falls == 1) begin
            // R9: stretch lasts 16 strobes after acceptance
            chk(rx_wmin >= (OSR - 1) * OS_DIV + 1 && rx_wmax <= OSR * OS_DIV,
                "R9", "stretch width", rx_wmax, OSR * OS_DIV);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        chk(ir_tx == 1'b0, "R1", "ir_tx in reset", int'(ir_tx), 0);
        chk(uart_rxd == 1'b1, "R1", "uart_rxd in reset", int'(uart_rxd), 1);
        rst_n = 1'b1;
        cyc();
        chk(!ir_tx && uart_rxd, "R1", "outputs after reset", int'(ir_tx), 0);

        // R2, R3, R4: normal-mode encoding, width 3 strobes
        lp_mode = 1'b0;
        psc = 8'd7;
        frame(8'h55, 3 * OS_DIV, "R2");
        frame(8'h00, 3 * OS_DIV, "R4");
        frame(8'hFF, 3 * OS_DIV, "R3");
        frame(8'hA3, 3 * OS_DIV, "R2");
        psc = 8'd0;
        frame(8'h0F, 3 * OS_DIV, "R2");

        // R5: low-power widths track the prescaler
        lp_mode = 1'b1;
        for (int p = 1; p <= 5; p++) begin
            psc = 8'(p);
            frame(8'h5A, 3 * p, "R5");
        end
        psc = 8'd10;
        frame(8'h00, 30, "R5");

        // R6: stopped low-power clock
        psc = 8'd0;
        frame(8'h00, 0, "R6");
        rx_trial(40, 0, "R6");
        lp_mode = 1'b0;
        rx_trial(40, 0, "R6");

        // R7: normal-mode glitch threshold of psc cycles
        for (int p = 1; p <= 3; p++) begin
            psc = 8'(p);
            for (int len = 1; len <= 2 * p + 3; len++)
                rx_trial(len, (len >= p) ? 1 : 0, "R7");
        end

        // R8: low-power acceptance needs at least 2*psc+1 cycles
        lp_mode = 1'b1;
        for (int p = 1; p <= 3; p++) begin
            psc = 8'(p);
            for (int len = 1; len <= 2 * p + 3; len++)
                rx_trial(len, (len >= 2 * p + 1) ? 1 : 0, "R8");
        end

        // R9: a long low run yields one acceptance only
        psc = 8'd2;
        repeat (10) cyc();
        clear_mon();
        cyc();
        ir_rx = 1'b0;
        repeat (150) cyc();
        ir_rx = 1'b1;
        repeat (100) cyc();
        chk(rx_falls == 1, "R9", "single accept on long low", rx_falls, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule